// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts what a processor core does, for profiling software. It has one 32-bit cycle counter and two 32-bit event counters. Each event counter watches one line of a bank of hardware event lines, picked by an 8-bit code. Software reaches the unit through four registers on a simple single-cycle bus: a combined control/status register and one register per counter.

The control register holds several fields: the global enable, the counter reset pulses, a mode that slows the cycle counter to one step every 64 clocks, three interrupt enables, three sticky overflow flags, and the two event-select codes. A counter that wraps from all ones to zero sets its own overflow flag. Flags from different counters add up; a new overflow never removes an older one. Software clears flags by writing ones to their positions, so writing back a value just read clears exactly the flags that were seen. The interrupt request is high while any flag whose enable is set is pending.

Reads are combinational from the addressed register. Writes take effect at the clock edge on which the write enable is high.

Top module: `pmu_counter_unit`

## Requirements
- R1: While control bit 0 (enable) is 0, no counter changes value except through a register write or a reset bit.
- R2: While enabled, with bit 3 clear, the cycle counter (index 1) increases by one on every clock edge. Each event counter increases by one on every edge where its selected event line is high.
- R3: Writing 1 to control bit 1 zeroes both event counters. Writing 1 to bit 2 zeroes the cycle counter and its divide phase. Neither touches the other counters, and both bits read back as 0.
- R4: With control bit 3 set, the cycle counter advances on the 64th, 128th, … enabled clock edge after its reset, instead of on every edge.
- R5: Event counter 0 takes its code from bits 12–19 and event counter 1 from bits 20–27. Code c counts event line c only when c is in 0x00–0x0D or 0x10–0x16 and below the line count (32). Code 0xFF and every other code count nothing.
- R6: Register index 0 is control, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A write to a counter index loads that value, and a read returns the current value.
- R7: Interrupt enable bits are bit 4 (event counter 0), bit 5 (event counter 1) and bit 6 (cycle counter). The irq output is high exactly while some overflow flag is set together with its enable.
- R8: Control bits 7, 11 and 28–31 always read 0. The enable, divide, interrupt-enable and event-select fields read back as last written.
- R9: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag: bit 8 (event counter 0), bit 9 (event counter 1) or bit 10 (cycle counter). Loading a value by a write sets no flag.
- R10: An overflow flag stays set until a control write carries a 1 at its position. Writing 0 there leaves it set, and an overflow on one counter never clears another counter's flag.
- R11: If a clearing write and a new overflow hit the same flag on the same edge, the flag ends up set.
- R12: After reset, every register reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register index (0 control, 1 cycle, 2 event 0, 3 event 1) |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| evt_lines | input | 32 | Hardware event lines, line n selected by code n |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag-clearing write landing on the same edge as a fresh overflow of that counter. The bench loads event counter 1 with 0xFFFFFFFF and enables counting with its event line held high. It then issues the clear-and-disable write on the very next edge, so the wrap and the clear meet. A second hard spot is the divide-by-64 boundary: the bench first zeroes the divide phase through the cycle reset bit, then holds the enable for exactly 128 edges and expects a count of two.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

   // register indices on the bus
   typedef enum logic [1:0] {
      IDX_CTRL = 2'd0,
      IDX_CYC  = 2'd1,
      IDX_EV0  = 2'd2,
      IDX_EV1  = 2'd3
   } pmu_idx_e;

   localparam int REG_W      = 32;
   localparam int CODE_W     = 8;
   localparam int NUM_EVT    = 2;
   localparam int NUM_SRC    = NUM_EVT + 1;   // ev0, ev1, cycle
   localparam int SRC_CYC    = NUM_EVT;

   // control field positions
   localparam int F_EN       = 0;
   localparam int F_CLR_EV   = 1;
   localparam int F_CLR_CYC  = 2;
   localparam int F_DIV      = 3;
   localparam int F_IE_LSB   = 4;
   localparam int F_OVF_LSB  = 8;
   localparam int F_SEL0_LSB = 12;
   localparam int F_SEL_STEP = 8;

   localparam logic [CODE_W-1:0] CODE_IDLE = 8'hFF;

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             inc,
   output logic [CNT_W-1:0] val,
   output logic             wrap
);

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("pmu_counter: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val <= '0;
      else if (clr) val <= '0;
      else if (ld)  val <= ld_val;
      else if (inc) val <= val + 1'b1;
   end

   // step from all ones to zero by counting, not by loading
   assign wrap = inc && !clr && !ld && (&val);

endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
   parameter int          NUM_LINES  = 32,
   parameter int          CODE_W     = 8,
   parameter logic [63:0] VALID_MASK = 64'h0000_0000_007F_3FFF
) (
   input  logic [CODE_W-1:0]    code,
   input  logic [NUM_LINES-1:0] lines,
   output logic                 hit
);

   localparam int CODES = 1 << CODE_W;

   generate
      if (NUM_LINES > 64 || NUM_LINES >= CODES - 1) begin : g_bad_lines
         $error("pmu_evt_sel: line count exceeds code space or mask");
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (code == CODE_W'(i) && VALID_MASK[i]) hit = lines[i];
      end
   end

endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
   parameter int DIV_LOG2 = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic slow,
   output logic tick
);

   generate
      if (DIV_LOG2 == 0) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         logic [DIV_LOG2-1:0] phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            phase <= '0;
            else if (clr)          phase <= '0;
            else if (run && slow)  phase <= phase + 1'b1;
         end
         assign tick = run && (!slow || (&phase));
      end
   endgenerate

endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
   import pmu_pkg::*;
(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic [REG_W-1:0]            wdata,
   input  logic [NUM_SRC-1:0]          wrap,
   output logic                        en,
   output logic                        slow,
   output logic [NUM_SRC-1:0]          ie,
   output logic [NUM_SRC-1:0]          ovf,
   output logic [NUM_EVT-1:0][CODE_W-1:0] sel,
   output logic                        clr_ev,
   output logic                        clr_cyc,
   output logic [REG_W-1:0]            rdata
);

   localparam int SEL_TOP = F_SEL0_LSB + NUM_EVT*F_SEL_STEP;

   generate
      if (SEL_TOP > REG_W || F_IE_LSB + NUM_SRC > F_OVF_LSB) begin : g_bad_map
         $error("pmu_ctrl: control fields overlap or overflow the register");
      end
   endgenerate

   assign clr_ev  = wr && wdata[F_CLR_EV];
   assign clr_cyc = wr && wdata[F_CLR_CYC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         slow <= 1'b0;
         ie   <= '0;
      end else if (wr) begin
         en   <= wdata[F_EN];
         slow <= wdata[F_DIV];
         ie   <= wdata[F_IE_LSB +: NUM_SRC];
      end
   end

   genvar s;
   generate
      for (s = 0; s < NUM_SRC; s++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ovf[s] <= 1'b0;
            else        ovf[s] <= (ovf[s] && !(wr && wdata[F_OVF_LSB+s])) || wrap[s];
         end
      end
      for (s = 0; s < NUM_EVT; s++) begin : g_sel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  sel[s] <= '0;
            else if (wr) sel[s] <= wdata[F_SEL0_LSB + s*F_SEL_STEP +: CODE_W];
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      rdata[F_EN]                  = en;
      rdata[F_DIV]                 = slow;
      rdata[F_IE_LSB +: NUM_SRC]   = ie;
      rdata[F_OVF_LSB +: NUM_SRC]  = ovf;
      for (int k = 0; k < NUM_EVT; k++) begin
         rdata[F_SEL0_LSB + k*F_SEL_STEP +: CODE_W] = sel[k];
      end
   end

endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
   import pmu_pkg::*;
#(
   parameter int          CNT_W      = 32,
   parameter int          NUM_LINES  = 32,
   parameter int          DIV_LOG2   = 6,
   parameter logic [63:0] VALID_MASK = 64'h0000_0000_007F_3FFF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           reg_addr,
   input  logic                 reg_we,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [NUM_LINES-1:0] evt_lines,
   output logic                 irq
);

   generate
      if (CNT_W > REG_W) begin : g_bad_cnt
         $error("pmu_counter_unit: CNT_W wider than the register bus");
      end
   endgenerate

   logic                          wr_ctrl, wr_cyc;
   logic [NUM_EVT-1:0]            wr_ev;
   logic                          en_q, slow_q, clr_ev, clr_cyc, cyc_tick;
   logic [NUM_SRC-1:0]            ie_q, ovf_q, wrap_v;
   logic [NUM_EVT-1:0][CODE_W-1:0] sel_q;
   logic [REG_W-1:0]              ctrl_rd;
   logic [CNT_W-1:0]              cyc_val;
   logic [NUM_EVT-1:0][CNT_W-1:0] ev_val;
   logic [NUM_EVT-1:0]            ev_hit;
   logic                          cyc_wrap;
   logic [NUM_EVT-1:0]            ev_wrap;

   assign wr_ctrl = reg_we && (reg_addr == IDX_CTRL);
   assign wr_cyc  = reg_we && (reg_addr == IDX_CYC);
   assign wr_ev[0] = reg_we && (reg_addr == IDX_EV0);
   assign wr_ev[1] = reg_we && (reg_addr == IDX_EV1);

   pmu_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_ctrl),
      .wdata   (reg_wdata),
      .wrap    (wrap_v),
      .en      (en_q),
      .slow    (slow_q),
      .ie      (ie_q),
      .ovf     (ovf_q),
      .sel     (sel_q),
      .clr_ev  (clr_ev),
      .clr_cyc (clr_cyc),
      .rdata   (ctrl_rd)
   );

   pmu_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_cyc),
      .run   (en_q),
      .slow  (slow_q),
      .tick  (cyc_tick)
   );

   pmu_counter #(.CNT_W(CNT_W)) u_cyc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_cyc),
      .ld     (wr_cyc),
      .ld_val (reg_wdata[CNT_W-1:0]),
      .inc    (cyc_tick),
      .val    (cyc_val),
      .wrap   (cyc_wrap)
   );

   genvar e;
   generate
      for (e = 0; e < NUM_EVT; e++) begin : g_evt
         pmu_evt_sel #(
            .NUM_LINES  (NUM_LINES),
            .CODE_W     (CODE_W),
            .VALID_MASK (VALID_MASK)
         ) u_sel (
            .code  (sel_q[e]),
            .lines (evt_lines),
            .hit   (ev_hit[e])
         );
         pmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_ev),
            .ld     (wr_ev[e]),
            .ld_val (reg_wdata[CNT_W-1:0]),
            .inc    (en_q && ev_hit[e]),
            .val    (ev_val[e]),
            .wrap   (ev_wrap[e])
         );
      end
   endgenerate

   assign wrap_v = {cyc_wrap, ev_wrap};

   always_comb begin
      unique case (reg_addr)
         IDX_CTRL: reg_rdata = ctrl_rd;
         IDX_CYC:  reg_rdata = REG_W'(cyc_val);
         IDX_EV0:  reg_rdata = REG_W'(ev_val[0]);
         default:  reg_rdata = REG_W'(ev_val[1]);
      endcase
   end

   assign irq = |(ovf_q & ie_q);

endmodule

// File: rtl/pmu_counter_unit_chk.sv
module pmu_counter_unit_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       reg_addr,
   input logic             reg_we,
   input logic [31:0]      reg_wdata,
   input logic [31:0]      reg_rdata,
   input logic             en,
   input logic [CNT_W-1:0] cyc_val,
   input logic [CNT_W-1:0] ev0_val,
   input logic [CNT_W-1:0] ev1_val,
   input logic [2:0]       ovf,
   input logic             cyc_wrap
);

   logic       ctrl_wr;
   logic [2:0] keep;
   assign ctrl_wr = reg_we && (reg_addr == 2'd0);
   assign keep    = ovf & ~(ctrl_wr ? reg_wdata[10:8] : 3'b000);

   // R1
   frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !reg_we) |=> ($stable(cyc_val) && $stable(ev0_val) && $stable(ev1_val)));

   // R3
   ev_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && reg_wdata[1]) |=> (ev0_val == '0 && ev1_val == '0));

   // R8
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd0) |-> (reg_rdata[31:28] == 4'd0 && !reg_rdata[11] && !reg_rdata[7] && reg_rdata[2:1] == 2'd0));

   // R9
   wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_wrap |=> ovf[2]);

   // R10
   sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ovf & $past(keep)) == $past(keep)));

endmodule

bind pmu_counter_unit pmu_counter_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .en        (en_q),
   .cyc_val   (cyc_val),
   .ev0_val   (ev_val[0]),
   .ev1_val   (ev_val[1]),
   .ovf       (ovf_q),
   .cyc_wrap  (cyc_wrap)
);

// File: tb/pmu_counter_unit_test.sv
`timescale 1ns/1ps
module pmu_counter_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] evt_lines = '0;
   logic        irq;

   int n_checks = 0;
   int n_fail = 0;
   bit mon_go = 1'b0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       req;
   } item_t;
   item_t exp_q[$];

   always #2.5 clk = ~clk;

   pmu_counter_unit uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_lines (evt_lines),
      .irq       (irq)
   );

   // monitor: compares the design's outputs against queued expectations
   always @(negedge clk) begin
      #1;
      if (mon_go && exp_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = exp_q.pop_front();
         act = it.is_irq ? {31'd0, irq} : reg_rdata;
         n_checks++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
         end
      end
   end

   // all tasks start and end at a falling edge
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic expect_rd(input logic [1:0] a, input logic [31:0] e, input string req);
      item_t it;
      it.is_irq = 1'b0; it.exp = e; it.req = req;
      exp_q.push_back(it);
      reg_addr = a; mon_go = 1'b1;
      @(negedge clk);
      mon_go = 1'b0;
   endtask

   task automatic expect_irq(input logic e, input string req);
      item_t it;
      it.is_irq = 1'b1; it.exp = {31'd0, e}; it.req = req;
      exp_q.push_back(it);
      mon_go = 1'b1;
      @(negedge clk);
      mon_go = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R12 reset state
      expect_rd(2'd0, 32'h0, "R12 ctrl");
      expect_rd(2'd1, 32'h0, "R12 cyc");
      expect_rd(2'd2, 32'h0, "R12 ev0");
      expect_rd(2'd3, 32'h0, "R12 ev1");
      expect_irq(1'b0, "R12 irq");

      // R8 reserved bits, pulses and flags read zero
      wr(2'd0, 32'hFFFF_FFFF);
      expect_rd(2'd0, 32'h0FFF_F079, "R8 ctrl readback");
      wr(2'd0, 32'h0000_0006);

      // R6 load, R1 frozen while disabled
      evt_lines = 32'hFFFF_FFFF;
      wr(2'd1, 32'd5);
      idle(10);
      expect_rd(2'd1, 32'd5, "R1 R6 cyc held");
      expect_rd(2'd2, 32'd0, "R1 ev0 held");

      // R2 counting for 10 edges, R5 code 0xFF idle
      wr(2'd0, 32'h0FF0_5001);
      idle(9);
      wr(2'd0, 32'h0FF0_5000);
      expect_rd(2'd1, 32'd15, "R2 cyc");
      expect_rd(2'd2, 32'd10, "R2 ev0");
      expect_rd(2'd3, 32'd0, "R5 code FF");

      // R5 valid 0x16 counts, unbacked 0x0E does not
      wr(2'd0, 32'h0FF0_5006);
      wr(2'd0, 32'h00E1_6001);
      idle(3);
      wr(2'd0, 32'h00E1_6000);
      expect_rd(2'd2, 32'd4, "R5 code 16");
      expect_rd(2'd3, 32'd0, "R5 code 0E");
      expect_rd(2'd1, 32'd4, "R2 cyc short run");

      // R3 separate reset pulses
      wr(2'd0, 32'h00E1_6004);
      expect_rd(2'd1, 32'd0, "R3 cyc cleared");
      expect_rd(2'd2, 32'd4, "R3 ev0 kept");
      wr(2'd0, 32'h00E1_6002);
      expect_rd(2'd2, 32'd0, "R3 ev0 cleared");
      expect_rd(2'd0, 32'h00E1_6000, "R3 pulse bits read 0");

      // R4 divide by 64: 128 enabled edges give 2
      evt_lines = '0;
      wr(2'd0, 32'h0FFF_F004);
      wr(2'd0, 32'h0FFF_F009);
      idle(127);
      wr(2'd0, 32'h0FFF_F000);
      expect_rd(2'd1, 32'd2, "R4 divided cycles");

      // R9 cycle wrap sets bit 10, R7 irq
      wr(2'd1, 32'hFFFF_FFFE);
      wr(2'd0, 32'h0FFF_F041);
      idle(1);
      wr(2'd0, 32'h0FFF_F040);
      expect_rd(2'd1, 32'd0, "R9 cyc wrapped");
      expect_rd(2'd0, 32'h0FFF_F440, "R9 cyc flag");
      expect_irq(1'b1, "R7 irq on");

      // R10 flags accumulate
      wr(2'd2, 32'hFFFF_FFFF);
      evt_lines = 32'h1;
      wr(2'd0, 32'h0FF0_0041);
      wr(2'd0, 32'h0FF0_0040);
      expect_rd(2'd0, 32'h0FF0_0540, "R10 accumulate");
      expect_rd(2'd2, 32'd0, "R9 ev0 wrapped");

      // R7 irq gated by enable
      wr(2'd0, 32'h0FF0_0000);
      expect_irq(1'b0, "R7 irq masked");
      expect_rd(2'd0, 32'h0FF0_0500, "R10 zero write keeps flags");

      // R10 write-one-to-clear, then write back
      wr(2'd0, 32'h0FF0_0100);
      expect_rd(2'd0, 32'h0FF0_0400, "R10 clear bit8");
      wr(2'd0, 32'h0FF0_0400);
      expect_rd(2'd0, 32'h0FF0_0000, "R10 write back");

      // R11 clear and wrap on the same edge
      wr(2'd3, 32'hFFFF_FFFF);
      evt_lines = 32'h2;
      wr(2'd0, 32'h0010_0001);
      wr(2'd0, 32'h0010_0200);
      expect_rd(2'd0, 32'h0010_0200, "R11 flag survives");
      expect_rd(2'd3, 32'd0, "R11 ev1 wrapped");
      expect_irq(1'b0, "R7 no enable");
      wr(2'd0, 32'h0010_0020);
      expect_irq(1'b1, "R7 enable pending");

      idle(2);
      done = 1'b1;
      finish_run();
   end

endmodule